// File: doc/BRIEF.md
# Register Dependency Interlock Scoreboard

This block finds read-after-write hazards for an in-order pipeline that has no bypass paths. It keeps one busy bit per architectural register. A bit goes up when an instruction that has a destination leaves the register-read stage for execute. The bit drops when that instruction completes write-back. The instruction queued in front of register read has its source identifiers compared against the busy bits. On a hit, a stall output holds fetch, decode and register read in place until the producer has written back, so program order is kept.

Write-back takes effect early in its cycle. A source that is being written back in the current cycle is therefore not a hazard. A source that is the destination of the instruction issuing to execute in the same cycle is a hazard. Instructions that skip register read, such as immediate moves, never stall. A flush input takes a mask of registers whose pending producers were squashed and clears their busy bits. Stores and conditional branches present up to three sources and no destination.

Top module: `reg_interlock`

## Requirements
- R1: While reset is applied, and after reset until the first issue, every busy bit is 0 and the stall output is low.
- R2: An issue strobe with the destination-valid flag high sets the busy bit of that destination from the next cycle. An issue with the flag low changes no bit.
- R3: A write-back strobe clears the busy bit of its register from the next cycle, unless R4 applies.
- R4: When a write-back and an issue name the same register in the same cycle, that register's busy bit stays 1.
- R5: Stall is high in the same cycle when the waiting instruction is valid, uses register read, and has a valid source whose register is busy. Otherwise stall is low.
- R6: A source whose valid flag is low never causes a stall, whatever its identifier.
- R7: When the uses-register-read input is 0, stall is low regardless of sources and busy bits.
- R8: A source that matches the register being written back in the current cycle does not stall, unless R9 applies.
- R9: A source that matches the destination of an instruction issuing with a valid destination in the current cycle stalls in that cycle.
- R10: On flush, every register whose bit is set in the flush mask has its busy bit cleared from the next cycle, and unmasked bits are unaffected. A same-cycle issue to a masked register leaves that bit set.
- R11: The busy vector output shows the stored busy bits (bit i is register i) and holds its value in any cycle with no issue, write-back or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rr_vld | input | 1 | An instruction is waiting to enter register read |
| rr_uses_rr | input | 1 | The waiting instruction needs the register-read stage |
| rr_src_vld | input | NUM_SRC | Per-source valid flags |
| rr_src_id | input | NUM_SRC*ID_W | Source register identifiers, source k in bits [k*ID_W +: ID_W] |
| iss_go | input | 1 | An instruction moves from register read into execute this cycle |
| iss_dst_vld | input | 1 | The issuing instruction writes a register |
| iss_dst_id | input | ID_W | Destination register of the issuing instruction |
| wb_go | input | 1 | An instruction completes write-back this cycle |
| wb_dst_id | input | ID_W | Register being written back |
| flush | input | 1 | Squash in-flight producers named in the mask |
| flush_mask | input | NUM_REGS | Registers whose busy bit the flush clears |
| stall | output | 1 | Freeze fetch, decode and register read |
| busy | output | NUM_REGS | Busy bit per register |

## Verification
Write-back and issue can land in the same cycle, and so can write-back and a source check on the same register. Issue and flush can also overlap. Each of these overlaps has a directed case: a write-back and an issue to one register, a source read of a register in its write-back cycle, a source read of a register issuing in that cycle, and a flush whose mask covers the register being issued. Random cycles then mix all strobes on a small register set so that such overlaps happen often. The bench keeps its own busy model, with set taking priority over clear. It checks the stall output in the cycle of the stimulus and the busy vector one cycle later.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;
  localparam int unsigned ILK_DEF_REGS = 16;
  localparam int unsigned ILK_DEF_SRCS = 3;

  function automatic int unsigned ilk_idw(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ilk_onehot.sv
`timescale 1ns/1ps
module ilk_onehot #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ID_W     = 4
) (
  input  logic                en,
  input  logic [ID_W-1:0]     id,
  output logic [NUM_REGS-1:0] mask
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign mask[g] = en && (id == ID_W'(g));
  end
endmodule

// File: rtl/ilk_pend_bank.sv
`timescale 1ns/1ps
module ilk_pend_bank #(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_mask,
  input  logic [NUM_REGS-1:0] clr_mask,
  output logic [NUM_REGS-1:0] pend_q
);
  logic [NUM_REGS-1:0] pend_d;
  logic [NUM_REGS-1:0] pend_en;

  // a set wins over a clear on the same register
  always_comb begin
    pend_en = set_mask | clr_mask;
    pend_d  = set_mask;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (pend_en[g]) begin
        pend_q[g] <= pend_d[g];
      end
    end
  end
endmodule

// File: rtl/ilk_hazard.sv
`timescale 1ns/1ps
module ilk_hazard #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned NUM_SRC  = 3
) (
  input  logic                    rr_vld,
  input  logic                    rr_uses_rr,
  input  logic [NUM_SRC-1:0]      src_vld,
  input  logic [NUM_SRC*ID_W-1:0] src_id,
  input  logic [NUM_REGS-1:0]     hz_mask,
  output logic                    stall
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [ID_W-1:0] sid;
    assign sid        = src_id[k*ID_W +: ID_W];
    assign src_hit[k] = src_vld[k] && hz_mask[sid];
  end

  always_comb begin
    stall = rr_vld && rr_uses_rr && (|src_hit);
  end
endmodule

// File: rtl/reg_interlock.sv
`timescale 1ns/1ps
module reg_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned NUM_REGS = ILK_DEF_REGS,
  parameter int unsigned NUM_SRC  = ILK_DEF_SRCS,
  parameter int unsigned ID_W     = ilk_idw(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rr_vld,
  input  logic                    rr_uses_rr,
  input  logic [NUM_SRC-1:0]      rr_src_vld,
  input  logic [NUM_SRC*ID_W-1:0] rr_src_id,
  input  logic                    iss_go,
  input  logic                    iss_dst_vld,
  input  logic [ID_W-1:0]         iss_dst_id,
  input  logic                    wb_go,
  input  logic [ID_W-1:0]         wb_dst_id,
  input  logic                    flush,
  input  logic [NUM_REGS-1:0]     flush_mask,
  output logic                    stall,
  output logic [NUM_REGS-1:0]     busy
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[SYNC_STAGES-1];

  logic [NUM_REGS-1:0] set_mask;
  logic [NUM_REGS-1:0] wb_mask;
  logic [NUM_REGS-1:0] clr_mask;
  logic [NUM_REGS-1:0] hz_mask;
  logic [NUM_REGS-1:0] pend_q;

  ilk_onehot #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) i_set_dec (
    .en   (iss_go && iss_dst_vld),
    .id   (iss_dst_id),
    .mask (set_mask)
  );

  ilk_onehot #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) i_wb_dec (
    .en   (wb_go),
    .id   (wb_dst_id),
    .mask (wb_mask)
  );

  always_comb begin
    clr_mask = wb_mask | (flush ? flush_mask : '0);
    // write-back lands early in the cycle; the issuing producer is already in flight
    hz_mask  = (pend_q & ~wb_mask) | set_mask;
  end

  ilk_pend_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .pend_q   (pend_q)
  );

  ilk_hazard #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .NUM_SRC(NUM_SRC)) i_hz (
    .rr_vld     (rr_vld),
    .rr_uses_rr (rr_uses_rr),
    .src_vld    (rr_src_vld),
    .src_id     (rr_src_id),
    .hz_mask    (hz_mask),
    .stall      (stall)
  );

  assign busy = pend_q;
endmodule

// File: rtl/reg_interlock_chk.sv
`timescale 1ns/1ps
module reg_interlock_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ID_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rr_vld,
  input logic                rr_uses_rr,
  input logic                iss_go,
  input logic                iss_dst_vld,
  input logic [ID_W-1:0]     iss_dst_id,
  input logic                wb_go,
  input logic [ID_W-1:0]     wb_dst_id,
  input logic                flush,
  input logic [NUM_REGS-1:0] flush_mask,
  input logic                stall,
  input logic [NUM_REGS-1:0] busy
);
  AST_ISSUE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_go && iss_dst_vld) |=> busy[$past(iss_dst_id)]); // R2

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_go && !(iss_go && iss_dst_vld && iss_dst_id == wb_dst_id))
      |=> !busy[$past(wb_dst_id)]); // R3

  AST_SAME_REG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_go && iss_go && iss_dst_vld && iss_dst_id == wb_dst_id)
      |=> busy[$past(wb_dst_id)]); // R4

  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_vld |-> !stall); // R5

  AST_EXEMPT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_uses_rr |-> !stall); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !iss_go) |=> ((busy & $past(flush_mask)) == '0)); // R10

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_go && !wb_go && !flush) |=> $stable(busy)); // R11
endmodule

bind reg_interlock reg_interlock_chk #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .rr_vld      (rr_vld),
  .rr_uses_rr  (rr_uses_rr),
  .iss_go      (iss_go),
  .iss_dst_vld (iss_dst_vld),
  .iss_dst_id  (iss_dst_id),
  .wb_go       (wb_go),
  .wb_dst_id   (wb_dst_id),
  .flush       (flush),
  .flush_mask  (flush_mask),
  .stall       (stall),
  .busy        (busy)
);

// File: tb/test_reg_interlock.sv
`timescale 1ns/1ps
module test_reg_interlock;
  localparam int NR = 16;
  localparam int NS = 3;
  localparam int IW = 4;

  logic clk;
  logic rst_n;
  logic rr_vld, rr_uses_rr;
  logic [NS-1:0] rr_src_vld;
  logic [NS*IW-1:0] rr_src_id;
  logic iss_go, iss_dst_vld;
  logic [IW-1:0] iss_dst_id;
  logic wb_go;
  logic [IW-1:0] wb_dst_id;
  logic flush;
  logic [NR-1:0] flush_mask;
  logic stall;
  logic [NR-1:0] busy;

  int n_cmp;
  int n_bad;
  logic [NR-1:0] model;

  reg_interlock #(.NUM_REGS(NR), .NUM_SRC(NS)) i_reg_interlock (
    .clk(clk), .rst_n(rst_n), .rr_vld(rr_vld), .rr_uses_rr(rr_uses_rr),
    .rr_src_vld(rr_src_vld), .rr_src_id(rr_src_id), .iss_go(iss_go),
    .iss_dst_vld(iss_dst_vld), .iss_dst_id(iss_dst_id), .wb_go(wb_go),
    .wb_dst_id(wb_dst_id), .flush(flush), .flush_mask(flush_mask),
    .stall(stall), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NR-1:0] dec(input logic en, input logic [IW-1:0] id);
    logic [NR-1:0] m;
    m = '0;
    if (en) m[id] = 1'b1;
    return m;
  endfunction

  function automatic logic exp_stall(input logic [NR-1:0] pend);
    logic [NR-1:0] hz;
    logic hit;
    hz  = (pend & ~dec(wb_go, wb_dst_id)) | dec(iss_go && iss_dst_vld, iss_dst_id);
    hit = 1'b0;
    for (int k = 0; k < NS; k++)
      if (rr_src_vld[k] && hz[rr_src_id[k*IW +: IW]]) hit = 1'b1;
    return rr_vld && rr_uses_rr && hit;
  endfunction

  task automatic idle_inputs();
    rr_vld = 0; rr_uses_rr = 1; rr_src_vld = '0; rr_src_id = '0;
    iss_go = 0; iss_dst_vld = 0; iss_dst_id = '0;
    wb_go = 0; wb_dst_id = '0; flush = 0; flush_mask = '0;
  endtask

  // called just after a falling edge with inputs driven; covers one cycle
  task automatic step(input string stag, input string ptag);
    logic [NR-1:0] nxt;
    #1;
    check(stag, 32'(stall), 32'(exp_stall(model)));
    nxt = (model & ~dec(wb_go, wb_dst_id) & ~(flush ? flush_mask : '0))
          | dec(iss_go && iss_dst_vld, iss_dst_id);
    model = nxt;
    @(negedge clk);
    check(ptag, 32'(busy), 32'(model));
    idle_inputs();
  endtask

  task automatic src(input int k, input logic [IW-1:0] id);
    rr_src_vld[k] = 1'b1;
    rr_src_id[k*IW +: IW] = id;
  endtask

  initial begin : wdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; model = '0;
    idle_inputs();
    rst_n = 0;
    #1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 0);
    rr_vld = 1; src(0, 4'd0);
    #1 check("R1 stall in reset", 32'(stall), 0);
    idle_inputs();
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 0);

    // R2: issue r3 sets, issue without destination does nothing
    iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd3; step("R2 stall", "R2 set r3");
    iss_go = 1; iss_dst_vld = 0; iss_dst_id = 4'd5; step("R2 stall", "R2 no-dst issue");
    // R11: idle cycle holds
    step("R11 stall", "R11 hold");
    // R5 / R6 / R7
    rr_vld = 1; src(1, 4'd3); step("R5 stall on busy src", "R5 busy");
    rr_vld = 1; src(1, 4'd3); rr_src_vld = '0; step("R6 invalid src", "R6 busy");
    rr_vld = 1; src(2, 4'd3); rr_uses_rr = 0; step("R7 exempt", "R7 busy");
    rr_vld = 0; src(0, 4'd3); step("R5 no valid instr", "R5 busy");
    // R8 then R3
    rr_vld = 1; src(0, 4'd3); wb_go = 1; wb_dst_id = 4'd3; step("R8 wb same cycle", "R3 clear r3");
    // R9: issue r4 while reading r4
    rr_vld = 1; src(2, 4'd4); iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd4;
    step("R9 issue same cycle", "R2 set r4");
    // R4 with R9: wb r4 and issue r4 together
    rr_vld = 1; src(0, 4'd4); wb_go = 1; wb_dst_id = 4'd4;
    iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd4;
    step("R9 wb+issue stall", "R4 keep r4");
    // R10: set r7, then flush {4,7,2} while issuing r2
    iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd7; step("R10 stall", "R2 set r7");
    iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd9; step("R10 stall", "R2 set r9");
    flush = 1; flush_mask = 16'h0094; iss_go = 1; iss_dst_vld = 1; iss_dst_id = 4'd2;
    step("R10 stall", "R10 flush masked");
    check("R10 r9 untouched", 32'(busy[9]), 1);
    check("R10 r2 issue wins", 32'(busy[2]), 1);

    // random mix on a small register set to provoke overlaps
    void'($urandom(32'd1234));
    for (int c = 0; c < 3000; c++) begin
      rr_vld      = ($urandom % 4) != 0;
      rr_uses_rr  = ($urandom % 8) != 0;
      for (int k = 0; k < NS; k++) begin
        rr_src_vld[k] = ($urandom % 3) != 0;
        rr_src_id[k*IW +: IW] = IW'($urandom % 6);
      end
      iss_go      = ($urandom % 2) != 0;
      iss_dst_vld = ($urandom % 4) != 0;
      iss_dst_id  = IW'($urandom % 6);
      wb_go       = ($urandom % 2) != 0;
      wb_dst_id   = IW'($urandom % 6);
      flush       = ($urandom % 20) == 0;
      flush_mask  = NR'($urandom);
      step("R5 random stall", "R11 random busy");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule